// File: doc/BRIEF.md
# Multi-format floating-point classifier

This block sorts one floating-point operand into one of ten categories and reports the result as a one-hot mask. A two-bit format select chooses how the 64-bit operand is read: as half precision (low 16 bits), single precision (low 32 bits) or double precision (all 64 bits). The sign, exponent and fraction fields of the chosen format are decoded, and the value is reported as infinity, zero, subnormal, normal, signalling NaN or quiet NaN. Infinity, zero, subnormal and normal are each split by sign. The NaN categories ignore the sign. The block raises no exceptions and sets no status flags.

Operands enter on a valid/ready stream and results leave on another. A single output register sits between them, so each result is due one cycle after its operand is accepted. An accepted operand occupies the output register until the consumer takes it with `out_ready`. While the output holds an untaken result, `in_ready` is low and no new operand is accepted. When the consumer takes the held result, a new operand can be accepted on that same edge, so a full-rate stream has no bubbles. The mask is zero-extended to the register width.

Top module: `fp_classify`

## Requirements
- R1: An infinity (exponent all ones, fraction zero) sets bit 0 when the sign is 1 and bit 7 when the sign is 0.
- R2: A zero (exponent and fraction all zero) sets bit 3 when negative and bit 4 when positive.
- R3: A subnormal (exponent all zero, fraction nonzero) sets bit 2 when negative and bit 5 when positive.
- R4: A normal number (exponent neither all zeros nor all ones) sets bit 1 when negative and bit 6 when positive.
- R5: A NaN (exponent all ones, fraction nonzero) sets bit 9 when the top fraction bit is 1 (quiet) and bit 8 when it is 0 (signalling), for either sign.
- R6: `in_fmt` 0 selects half precision (bits 15:0, 5-bit exponent), 1 selects single (bits 31:0, 8-bit exponent), and 2 or 3 select double (bits 63:0, 11-bit exponent). In half and single mode the operand bits above the format have no effect on the result.
- R7: Whenever `out_valid` is high, exactly one of `out_class[9:0]` is set. Bits above bit 9 are always zero.
- R8: An operand accepted on a rising edge (`in_valid` and `in_ready` both high) appears on `out_class` with `out_valid` high right after that edge. If nothing new is accepted, `out_valid` falls after the edge on which the result is taken.
- R9: `in_ready` is high when `out_valid` is low or `out_ready` is high. While `out_valid` is high and `out_ready` is low, both `out_valid` and `out_class` hold their values.
- R10: While `rst_n` is low, `out_valid` and `out_class` are zero and `in_ready` is high. The reset is asynchronous.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand and format are presented |
| in_ready | output | 1 | Block can accept an operand this cycle |
| in_fmt | input | 2 | Format: 0 half, 1 single, 2 or 3 double |
| in_operand | input | 64 | Floating-point operand, right-aligned |
| out_valid | output | 1 | `out_class` holds an untaken result |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_class | output | XLEN (64) | One-hot class mask in bits 9:0, zero above |

## Verification
Each classification is due one rising edge after it is accepted, because it passes through exactly one register. The bench drives inputs on falling edges and checks the mask and `out_valid` on the falling edge that follows the accepting rising edge. The stall sequence checks on each falling edge while `out_ready` is low, to confirm the held value does not change. It then raises `out_ready` and checks the next result on the falling edge after the refill edge. One further falling edge later, it checks that `out_valid` has dropped. The reset values are checked combinationally on a falling edge while reset is held low.

// File: rtl/fpc_pkg.sv
package fpc_pkg;

  localparam int NUM_FMT  = 3;
  localparam int CLASS_W  = 10;
  localparam int OPND_W   = 64;

  typedef enum logic [1:0] {
    FMT_HALF    = 2'd0,
    FMT_SINGLE  = 2'd1,
    FMT_DOUBLE  = 2'd2,
    FMT_DOUBLE2 = 2'd3
  } fpc_fmt_e;

  // Bit positions of the class mask.
  localparam int CLS_NEG_INF  = 0;
  localparam int CLS_NEG_NORM = 1;
  localparam int CLS_NEG_SUB  = 2;
  localparam int CLS_NEG_ZERO = 3;
  localparam int CLS_POS_ZERO = 4;
  localparam int CLS_POS_SUB  = 5;
  localparam int CLS_POS_NORM = 6;
  localparam int CLS_POS_INF  = 7;
  localparam int CLS_SNAN     = 8;
  localparam int CLS_QNAN     = 9;

  // Condensed field facts shared by every format.
  typedef struct packed {
    logic sign;
    logic exp_ones;
    logic exp_zero;
    logic frac_zero;
    logic frac_top;
  } fpc_fields_t;

  function automatic int exp_width(input int idx);
    case (idx)
      0:       return 5;
      1:       return 8;
      default: return 11;
    endcase
  endfunction

  function automatic int frac_width(input int idx);
    case (idx)
      0:       return 10;
      1:       return 23;
      default: return 52;
    endcase
  endfunction

endpackage

// File: rtl/fpc_field_extract.sv
module fpc_field_extract
  import fpc_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int TOT_W = 1 + EXP_W + FRAC_W
) (
  input  logic [TOT_W-1:0] value,
  output fpc_fields_t      fields
);

  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;

  assign exp_f  = value[TOT_W-2 -: EXP_W];
  assign frac_f = value[FRAC_W-1:0];

  always_comb begin
    fields.sign      = value[TOT_W-1];
    fields.exp_ones  = &exp_f;
    fields.exp_zero  = ~|exp_f;
    fields.frac_zero = ~|frac_f;
    fields.frac_top  = frac_f[FRAC_W-1];
  end

endmodule

// File: rtl/fpc_decode.sv
module fpc_decode
  import fpc_pkg::*;
(
  input  fpc_fields_t        fields,
  output logic [CLASS_W-1:0] mask
);

  always_comb begin
    mask = '0;
    if (fields.exp_ones && fields.frac_zero) begin
      mask[fields.sign ? CLS_NEG_INF : CLS_POS_INF] = 1'b1;
    end else if (fields.exp_zero && fields.frac_zero) begin
      mask[fields.sign ? CLS_NEG_ZERO : CLS_POS_ZERO] = 1'b1;
    end else if (fields.exp_zero) begin
      mask[fields.sign ? CLS_NEG_SUB : CLS_POS_SUB] = 1'b1;
    end else if (fields.exp_ones) begin
      mask[fields.frac_top ? CLS_QNAN : CLS_SNAN] = 1'b1;
    end else begin
      mask[fields.sign ? CLS_NEG_NORM : CLS_POS_NORM] = 1'b1;
    end
  end

endmodule

// File: rtl/fpc_out_stage.sv
module fpc_out_stage #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [W-1:0] in_data,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_data
);

  logic load;

  assign in_ready = !out_valid || out_ready;
  assign load     = in_valid && in_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_data  <= in_data;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/fp_classify.sv
module fp_classify
  import fpc_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  output logic            in_ready,
  input  logic [1:0]      in_fmt,
  input  logic [63:0]     in_operand,
  output logic            out_valid,
  input  logic            out_ready,
  output logic [XLEN-1:0] out_class
);

  localparam int PAD_W = XLEN - CLASS_W;

  fpc_fields_t        fmt_fields [NUM_FMT];
  fpc_fields_t        sel_fields;
  logic [CLASS_W-1:0] mask_d;
  logic [CLASS_W-1:0] mask_q;

  for (genvar g = 0; g < NUM_FMT; g++) begin : g_fmt
    localparam int EW = exp_width(g);
    localparam int FW = frac_width(g);
    fpc_field_extract #(
      .EXP_W (EW),
      .FRAC_W(FW)
    ) u_extract (
      .value (in_operand[EW+FW:0]),
      .fields(fmt_fields[g])
    );
  end

  always_comb begin
    case (fpc_fmt_e'(in_fmt))
      FMT_HALF:   sel_fields = fmt_fields[0];
      FMT_SINGLE: sel_fields = fmt_fields[1];
      default:    sel_fields = fmt_fields[NUM_FMT-1];
    endcase
  end

  fpc_decode u_decode (
    .fields(sel_fields),
    .mask  (mask_d)
  );

  fpc_out_stage #(
    .W(CLASS_W)
  ) u_stage (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .in_data  (mask_d),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (mask_q)
  );

  assign out_class = {{PAD_W{1'b0}}, mask_q};

endmodule

// File: rtl/fp_classify_chk.sv
module fp_classify_chk
  import fpc_pkg::*;
#(
  parameter int XLEN = 64
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            in_ready,
  input logic            out_valid,
  input logic            out_ready,
  input logic [XLEN-1:0] out_class
);

  // R7
  class_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $countones(out_class[CLASS_W-1:0]) == 1);

  // R7
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_class[XLEN-1:CLASS_W] == '0);

  // R8
  accept_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_class));

  // R9
  ready_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  // R10
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |-> !out_valid && out_class == '0);

endmodule

bind fp_classify fp_classify_chk #(.XLEN(XLEN)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .in_valid (in_valid),
  .in_ready (in_ready),
  .out_valid(out_valid),
  .out_ready(out_ready),
  .out_class(out_class)
);

// File: tb/fp_classify_bench.sv
`timescale 1ns/1ps
module fp_classify_bench;

  localparam int XLEN = 64;
  localparam int NV   = 31;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            in_valid;
  logic            in_ready;
  logic [1:0]      in_fmt;
  logic [63:0]     in_operand;
  logic            out_valid;
  logic            out_ready;
  logic [XLEN-1:0] out_class;

  int checks   = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  fp_classify #(.XLEN(XLEN)) u_fp_classify (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_fmt    (in_fmt),
    .in_operand(in_operand),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_class (out_class)
  );

  // {tag, fmt, operand, expected mask}
  localparam logic [79:0] VEC [NV] = '{
    {4'd1, 2'd0, 64'h0000_0000_0000_7C00, 10'h080},
    {4'd1, 2'd0, 64'h0000_0000_0000_FC00, 10'h001},
    {4'd2, 2'd0, 64'h0000_0000_0000_0000, 10'h010},
    {4'd2, 2'd0, 64'h0000_0000_0000_8000, 10'h008},
    {4'd3, 2'd0, 64'h0000_0000_0000_0001, 10'h020},
    {4'd3, 2'd0, 64'h0000_0000_0000_8200, 10'h004},
    {4'd4, 2'd0, 64'h0000_0000_0000_3C00, 10'h040},
    {4'd4, 2'd0, 64'h0000_0000_0000_C000, 10'h002},
    {4'd5, 2'd0, 64'h0000_0000_0000_7E00, 10'h200},
    {4'd5, 2'd0, 64'h0000_0000_0000_7C01, 10'h100},
    {4'd5, 2'd0, 64'h0000_0000_0000_FE00, 10'h200},
    {4'd6, 2'd0, 64'hDEAD_BEEF_1234_7C00, 10'h080},
    {4'd1, 2'd1, 64'h0000_0000_7F80_0000, 10'h080},
    {4'd1, 2'd1, 64'h0000_0000_FF80_0000, 10'h001},
    {4'd4, 2'd1, 64'h0000_0000_3F80_0000, 10'h040},
    {4'd3, 2'd1, 64'h0000_0000_0040_0000, 10'h020},
    {4'd2, 2'd1, 64'h0000_0000_8000_0000, 10'h008},
    {4'd5, 2'd1, 64'h0000_0000_7FC0_0000, 10'h200},
    {4'd5, 2'd1, 64'h0000_0000_FF80_0001, 10'h100},
    {4'd6, 2'd1, 64'hFFFF_FFFF_0000_0000, 10'h010},
    {4'd1, 2'd2, 64'h7FF0_0000_0000_0000, 10'h080},
    {4'd1, 2'd2, 64'hFFF0_0000_0000_0000, 10'h001},
    {4'd2, 2'd2, 64'h0000_0000_0000_0000, 10'h010},
    {4'd2, 2'd2, 64'h8000_0000_0000_0000, 10'h008},
    {4'd3, 2'd2, 64'h800F_FFFF_FFFF_FFFF, 10'h004},
    {4'd4, 2'd2, 64'hBFF0_0000_0000_0000, 10'h002},
    {4'd5, 2'd2, 64'h7FF8_0000_0000_0000, 10'h200},
    {4'd5, 2'd2, 64'h7FF0_0000_0000_0001, 10'h100},
    {4'd5, 2'd2, 64'hFFF4_0000_0000_0000, 10'h100},
    {4'd6, 2'd3, 64'h3FF0_0000_0000_0000, 10'h040},
    {4'd6, 2'd2, 64'h0000_0000_0000_7C00, 10'h020}
  };

  function automatic string tag_name(input logic [3:0] t);
    case (t)
      4'd1:    return "R1";
      4'd2:    return "R2";
      4'd3:    return "R3";
      4'd4:    return "R4";
      4'd5:    return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send_check(input logic [1:0] f, input logic [63:0] op,
                            input logic [9:0] exp, input string req);
    @(negedge clk);
    in_valid   = 1'b1;
    in_fmt     = f;
    in_operand = op;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check({req, " valid R8"}, {63'd0, out_valid}, 64'd1);
    // R7: upper bits compared as zero with the full width
    check(req, out_class, {54'd0, exp});
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    rst_n      = 1'b0;
    in_valid   = 1'b0;
    in_fmt     = 2'd0;
    in_operand = '0;
    out_ready  = 1'b1;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 out_valid", {63'd0, out_valid}, 64'd0);
    check("R10 out_class", out_class, 64'd0);
    check("R10 in_ready", {63'd0, in_ready}, 64'd1);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      send_check(VEC[i][75:74], VEC[i][73:10], VEC[i][9:0], tag_name(VEC[i][79:76]));
    end

    // R9: back-pressure
    @(negedge clk);
    out_ready  = 1'b0;
    in_valid   = 1'b1;
    in_fmt     = 2'd2;
    in_operand = 64'h3FF0_0000_0000_0000;
    @(posedge clk);
    @(negedge clk);
    check("R8 stalled load valid", {63'd0, out_valid}, 64'd1);
    check("R8 stalled load class", out_class, 64'h040);
    in_operand = 64'h7FF8_0000_0000_0000;
    check("R9 in_ready low when full", {63'd0, in_ready}, 64'd0);
    for (int k = 0; k < 3; k++) begin
      @(posedge clk);
      @(negedge clk);
      check("R9 hold valid", {63'd0, out_valid}, 64'd1);
      check("R9 hold class", out_class, 64'h040);
    end
    out_ready = 1'b1;
    #1;
    check("R9 in_ready with out_ready", {63'd0, in_ready}, 64'd1);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R9 refill class", out_class, 64'h200);
    check("R9 refill valid", {63'd0, out_valid}, 64'd1);
    @(posedge clk);
    @(negedge clk);
    check("R8 drain valid", {63'd0, out_valid}, 64'd0);

    // R10: asynchronous reset while a result is held
    out_ready  = 1'b0;
    in_valid   = 1'b1;
    in_fmt     = 2'd1;
    in_operand = 64'h0000_0000_7F80_0000;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check("R10 pre-reset valid", {63'd0, out_valid}, 64'd1);
    #2 rst_n = 1'b0;
    #1;
    check("R10 async valid", {63'd0, out_valid}, 64'd0);
    check("R10 async class", out_class, 64'd0);
    check("R10 async in_ready", {63'd0, in_ready}, 64'd1);
    @(negedge clk);
    rst_n     = 1'b1;
    out_ready = 1'b1;

    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      summary();
      $finish;
    end
  end

endmodule